// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Mapper

This block is the bank-switching logic of an 8-bit console game cartridge. The CPU programs it by writing to fixed addresses in the 0x8000–0xFFFF window. It then turns every CPU program-space address into a program ROM address made of four 8 KB windows. It turns every video-side pattern address (0x0000–0x1FFF) into a character ROM address made of eight 1 KB windows. It also drives the nametable mirroring selection.

An outer register feeds the other bank settings. Its bits [5:4] become the upper bits of every later character bank number. They also pick the outer group of the program ROM. Program banks can be set in 16 KB pairs or as single 8 KB windows, and the most recent write wins for each window. A static strap turns four of the character bank writes into 2 KB bank writes. A one-byte scratch register in the 0x5100 area can be read back by the CPU. The ROM size is a parameter, and bank numbers wrap to that size.

Writes are captured on the rising clock edge while the write strobe is high. The mapped addresses, the mirroring select and the read data are combinational from the held state and the current addresses.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, program windows 0 and 1 hold 8 KB banks 0 and 1. With PRG_BANKS of at least 32, windows 2 and 3 hold banks 30 and 31; with fewer banks they hold PRG_BANKS-2 and PRG_BANKS-1.
- R2: After reset, character window i holds 1 KB bank i (i = 0..7), mirror_mode is 0, the scratch byte is 0x00 and the outer bits are 0.
- R3: A write of d to 0x8000, 0xB000, 0xB0FF or 0xB1FF does four things. It stores d[5:4] as the outer bits. It sets program windows 0/1 to 8 KB banks 2d and 2d+1. It sets windows 2/3 to 2c and 2c+1, where c = (d & 0x30) | 0x0F.
- R4: A write of d to 0x8100 sets mirror_mode to d[1:0], with 0 = vertical, 1 = horizontal, 2 = single-screen low page and 3 = single-screen high page. Bits [7:2] have no effect on the output.
- R5: A write of d to 0x8300, 0x8301 or 0x8302 sets program window 0, 1 or 2 (CPU 0x8000, 0xA000, 0xC000) to 8 KB bank d. The other windows keep their banks.
- R6: With the strap low, a write of d to 0x8310+i (i = 0..7) sets character window i to 1 KB bank {outer bits, d}. A later outer write does not change windows that are already set.
- R7: With the strap high, writes to 0x8310, 0x8311, 0x8316 and 0x8317 set a 2 KB bank n = {outer bits, d} at PPU 0x0000, 0x0800, 0x1000 and 0x1800. Bank n fills the window pair with 1 KB banks 2n and 2n+1. Writes to 0x8312–0x8315 stay 1 KB writes.
- R8: A write of d to 0x8318 sets program windows 0/1 to 8 KB banks 2b and 2b+1, where b = (outer bits << 4) | d.
- R9: A write to 0x5101, 0x5102 or 0x5103 stores the byte in the scratch register. A write to 0x5100 leaves it unchanged.
- R10: cpu_rdata is the scratch byte when (cpu_addr & 0x5100) == 0x5100, and cpu_addr[15:8] otherwise.
- R11: prg_rom_addr = {bank mod PRG_BANKS, cpu_addr[12:0]}, with the window picked by cpu_addr[14:13]. chr_rom_addr = {bank mod CHR_BANKS, ppu_addr[9:0]}, with the window picked by ppu_addr[12:10]. Both sizes are powers of two.
- R12: A write takes effect on the clock edge that samples it. Cycles with cpu_we low, and writes to any other address, leave all mappings and mirror_mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address for writes, reads and program translation |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | Video pattern address |
| chr2k_mode | input | 1 | Static strap that turns on 2 KB character writes |
| cpu_rdata | output | 8 | Read data for the low register area |
| prg_rom_addr | output | $clog2(PRG_BANKS)+13 | Mapped program ROM byte address |
| chr_rom_addr | output | $clog2(CHR_BANKS)+10 | Mapped character ROM byte address |
| mirror_mode | output | 2 | Nametable mirroring select |

## Verification
The outer-bank write is swept over all 256 data values, and all four program windows are checked after each write. This shows whether the fixed upper pair and the 16 KB doubling are built correctly. Single 8 KB writes and 0x8318 writes are then mixed with different outer bits to see which write wins for each window. Character writes are tried with the strap low and high, and with all four outer settings, so that 1 KB, 2 KB and wrapped bank numbers are all exercised. A second instance with a small program ROM shows both the reset choice and the modulo wrap. Finally, a full sweep of read addresses, mirror writes with junk upper bits, idle cycles and writes to unused addresses show what each of those may and may not change.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_OUTER,
    OP_MIRROR,
    OP_PRG8K,
    OP_PRG16K,
    OP_CHR,
    OP_SCRATCH
  } wr_op_e;

  typedef struct packed {
    wr_op_e     op;
    logic [2:0] idx;
  } wr_cmd_t;

  localparam int PRG_SLOTS = 4;
  localparam int CHR_SLOTS = 8;
  localparam int PRG_OFF_W = 13;
  localparam int CHR_OFF_W = 10;
  // widest 8 KB bank number: 2*255+1
  localparam int PRG_REG_W = 9;
  // widest 1 KB bank number: 2*1023+1
  localparam int CHR_REG_W = 11;

endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode
  import cbm_pkg::*;
(
  input  logic        we,
  input  logic [15:0] addr,
  output wr_cmd_t     cmd
);

  always_comb begin
    cmd.op  = OP_NONE;
    cmd.idx = addr[2:0];
    if (we) begin
      case (addr)
        16'h8000, 16'hB000, 16'hB0FF, 16'hB1FF: cmd.op = OP_OUTER;
        16'h8100:                               cmd.op = OP_MIRROR;
        16'h8300, 16'h8301, 16'h8302:           cmd.op = OP_PRG8K;
        16'h8318:                               cmd.op = OP_PRG16K;
        16'h5101, 16'h5102, 16'h5103:           cmd.op = OP_SCRATCH;
        default: begin
          // 0x8310..0x8317 share one aligned group of eight
          if (addr[15:3] == 13'h1062) cmd.op = OP_CHR;
        end
      endcase
    end
  end

endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  wr_cmd_t                        cmd,
  input  logic [7:0]                     wdata,
  input  logic                           chr2k,
  output logic [PRG_SLOTS*PRG_REG_W-1:0] prg_slots,
  output logic [CHR_SLOTS*CHR_REG_W-1:0] chr_slots,
  output mirror_e                        mirror,
  output logic [7:0]                     scratch
);

  localparam logic [PRG_REG_W-1:0] RST_P2 =
    (PRG_BANKS >= 32) ? PRG_REG_W'(30) : PRG_REG_W'(PRG_BANKS - 2);
  localparam logic [PRG_REG_W-1:0] RST_P3 =
    (PRG_BANKS >= 32) ? PRG_REG_W'(31) : PRG_REG_W'(PRG_BANKS - 1);

  logic [PRG_REG_W-1:0] prg_q [PRG_SLOTS];
  logic [PRG_REG_W-1:0] prg_d [PRG_SLOTS];
  logic [CHR_REG_W-1:0] chr_q [CHR_SLOTS];
  logic [CHR_REG_W-1:0] chr_d [CHR_SLOTS];
  logic [1:0]           outer_q, outer_d;
  mirror_e              mir_q, mir_d;
  logic [7:0]           scr_q, scr_d;
  logic                 upd_en;

  logic [7:0] bank16_hi;
  logic [7:0] bank16_lo;
  logic [9:0] chr_val;
  logic       pair_sel;

  assign upd_en    = (cmd.op != OP_NONE);
  assign bank16_hi = {2'b00, wdata[5:4], 4'hF};
  assign bank16_lo = {wdata[7:6], wdata[5:4] | outer_q, wdata[3:0]};
  assign chr_val   = {outer_q, wdata};
  // writes 0,1,6,7 become 2 KB writes when the strap is high
  assign pair_sel  = chr2k && (cmd.idx[1] == cmd.idx[2]);

  always_comb begin
    for (int i = 0; i < PRG_SLOTS; i++) prg_d[i] = prg_q[i];
    for (int i = 0; i < CHR_SLOTS; i++) chr_d[i] = chr_q[i];
    outer_d = outer_q;
    mir_d   = mir_q;
    scr_d   = scr_q;
    case (cmd.op)
      OP_OUTER: begin
        outer_d  = wdata[5:4];
        prg_d[0] = {wdata, 1'b0};
        prg_d[1] = {wdata, 1'b1};
        prg_d[2] = {bank16_hi, 1'b0};
        prg_d[3] = {bank16_hi, 1'b1};
      end
      OP_MIRROR:  mir_d = mirror_e'(wdata[1:0]);
      OP_PRG8K:   prg_d[cmd.idx[1:0]] = {1'b0, wdata};
      OP_PRG16K: begin
        prg_d[0] = {bank16_lo, 1'b0};
        prg_d[1] = {bank16_lo, 1'b1};
      end
      OP_CHR: begin
        if (pair_sel) begin
          chr_d[{cmd.idx[2], cmd.idx[0], 1'b0}] = {chr_val, 1'b0};
          chr_d[{cmd.idx[2], cmd.idx[0], 1'b1}] = {chr_val, 1'b1};
        end else begin
          chr_d[cmd.idx] = {1'b0, chr_val};
        end
      end
      OP_SCRATCH: scr_d = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_q[0] <= PRG_REG_W'(0);
      prg_q[1] <= PRG_REG_W'(1);
      prg_q[2] <= RST_P2;
      prg_q[3] <= RST_P3;
      for (int i = 0; i < CHR_SLOTS; i++) chr_q[i] <= CHR_REG_W'(i);
      outer_q <= 2'b00;
      mir_q   <= MIR_VERT;
      scr_q   <= 8'h00;
    end else if (upd_en) begin
      for (int i = 0; i < PRG_SLOTS; i++) prg_q[i] <= prg_d[i];
      for (int i = 0; i < CHR_SLOTS; i++) chr_q[i] <= chr_d[i];
      outer_q <= outer_d;
      mir_q   <= mir_d;
      scr_q   <= scr_d;
    end
  end

  for (genvar g = 0; g < PRG_SLOTS; g++) begin : g_prg_flat
    assign prg_slots[g*PRG_REG_W +: PRG_REG_W] = prg_q[g];
  end
  for (genvar g = 0; g < CHR_SLOTS; g++) begin : g_chr_flat
    assign chr_slots[g*CHR_REG_W +: CHR_REG_W] = chr_q[g];
  end

  assign mirror  = mir_q;
  assign scratch = scr_q;

endmodule

// File: rtl/cbm_slot_xlate.sv
module cbm_slot_xlate #(
  parameter int SLOTS  = 4,
  parameter int OFF_W  = 13,
  parameter int REG_W  = 9,
  parameter int BANK_W = 9,
  localparam int SEL_W = $clog2(SLOTS)
) (
  input  logic [SLOTS*REG_W-1:0]   slots,
  input  logic [SEL_W+OFF_W-1:0]   addr,
  output logic [BANK_W+OFF_W-1:0]  rom_addr
);

  logic [REG_W-1:0]  bank_tbl [SLOTS];
  logic [SEL_W-1:0]  sel;
  logic [REG_W-1:0]  bank_raw;
  logic [BANK_W-1:0] bank_mod;

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign bank_tbl[g] = slots[g*REG_W +: REG_W];
  end

  assign sel      = addr[SEL_W+OFF_W-1:OFF_W];
  assign bank_raw = bank_tbl[sel];
  // power-of-two ROM size: modulo is a plain size cast
  assign bank_mod = BANK_W'(bank_raw);
  assign rom_addr = {bank_mod, addr[OFF_W-1:0]};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 512,
  parameter int CHR_BANKS = 1024,
  localparam int PRG_BW   = $clog2(PRG_BANKS),
  localparam int CHR_BW   = $clog2(CHR_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  input  logic                       cpu_we,
  input  logic [12:0]                ppu_addr,
  input  logic                       chr2k_mode,
  output logic [7:0]                 cpu_rdata,
  output logic [PRG_BW+PRG_OFF_W-1:0] prg_rom_addr,
  output logic [CHR_BW+CHR_OFF_W-1:0] chr_rom_addr,
  output logic [1:0]                 mirror_mode
);

  logic                           rst_meta_n, rst_sync_n;
  wr_cmd_t                        cmd;
  logic [PRG_SLOTS*PRG_REG_W-1:0] prg_slots;
  logic [CHR_SLOTS*CHR_REG_W-1:0] chr_slots;
  mirror_e                        mirror;
  logic [7:0]                     scratch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cbm_wr_decode u_dec (
    .we   (cpu_we),
    .addr (cpu_addr),
    .cmd  (cmd)
  );

  cbm_bank_regs #(.PRG_BANKS(PRG_BANKS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd       (cmd),
    .wdata     (cpu_wdata),
    .chr2k     (chr2k_mode),
    .prg_slots (prg_slots),
    .chr_slots (chr_slots),
    .mirror    (mirror),
    .scratch   (scratch)
  );

  cbm_slot_xlate #(
    .SLOTS(PRG_SLOTS), .OFF_W(PRG_OFF_W), .REG_W(PRG_REG_W), .BANK_W(PRG_BW)
  ) u_prg_xl (
    .slots    (prg_slots),
    .addr     (cpu_addr[14:0]),
    .rom_addr (prg_rom_addr)
  );

  cbm_slot_xlate #(
    .SLOTS(CHR_SLOTS), .OFF_W(CHR_OFF_W), .REG_W(CHR_REG_W), .BANK_W(CHR_BW)
  ) u_chr_xl (
    .slots    (chr_slots),
    .addr     (ppu_addr),
    .rom_addr (chr_rom_addr)
  );

  assign cpu_rdata   = ((cpu_addr & 16'h5100) == 16'h5100) ? scratch : cpu_addr[15:8];
  assign mirror_mode = mirror;

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int PRG_BW = 9,
  parameter int CHR_BW = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          cpu_addr,
  input logic [7:0]           cpu_wdata,
  input logic                 cpu_we,
  input logic [12:0]          ppu_addr,
  input logic [7:0]           cpu_rdata,
  input logic [PRG_BW+12:0]   prg_rom_addr,
  input logic [CHR_BW+9:0]    chr_rom_addr,
  input logic [1:0]           mirror_mode
);

  // R4: mirroring follows the low two bits of a write to 0x8100
  a_r4_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h8100) |=> (mirror_mode == $past(cpu_wdata[1:0])));

  // R12: no write strobe, no change of mirroring
  a_r12_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> $stable(mirror_mode));

  // R5: an 8 KB write to window 0 shows up on the next cycle
  a_r5_prg8k_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h8300) |=>
      (cpu_addr[15:13] != 3'b100 ||
       prg_rom_addr[PRG_BW+12:13] == PRG_BW'($past(cpu_wdata))));

  // R9: a stored scratch byte is what a 0x5100 read returns next
  a_r9_scratch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && (cpu_addr == 16'h5101 || cpu_addr == 16'h5102 || cpu_addr == 16'h5103)) |=>
      (cpu_addr != 16'h5100 || cpu_rdata == $past(cpu_wdata)));

  // R11: offsets pass through untouched
  a_r11_prg_offset: assert property (@(posedge clk) disable iff (!rst_n)
    prg_rom_addr[12:0] == cpu_addr[12:0]);

  a_r11_chr_offset: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rom_addr[9:0] == ppu_addr[9:0]);

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PRG_BW(PRG_BW), .CHR_BW(CHR_BW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .cpu_we       (cpu_we),
  .ppu_addr     (ppu_addr),
  .cpu_rdata    (cpu_rdata),
  .prg_rom_addr (prg_rom_addr),
  .chr_rom_addr (chr_rom_addr),
  .mirror_mode  (mirror_mode)
);

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;

  localparam int PB_BIG   = 512;
  localparam int PB_SMALL = 16;
  localparam int CB       = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic [12:0] ppu_addr;
  logic        chr2k_mode;

  logic [7:0]  rdata_b, rdata_s;
  logic [21:0] prg_b;
  logic [16:0] prg_s;
  logic [19:0] chr_b, chr_s;
  logic [1:0]  mir_b, mir_s;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int prg_mb [4];
  int prg_ms [4];
  int chr_m  [8];
  int outer_m, mir_m, scr_m;

  always #2.5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PB_BIG), .CHR_BANKS(CB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ppu_addr(ppu_addr), .chr2k_mode(chr2k_mode),
    .cpu_rdata(rdata_b), .prg_rom_addr(prg_b), .chr_rom_addr(chr_b),
    .mirror_mode(mir_b));

  cart_bank_mapper #(.PRG_BANKS(PB_SMALL), .CHR_BANKS(CB)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ppu_addr(ppu_addr), .chr2k_mode(chr2k_mode),
    .cpu_rdata(rdata_s), .prg_rom_addr(prg_s), .chr_rom_addr(chr_s),
    .mirror_mode(mir_s));

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model(input int a, input int d);
    int v, p;
    if (a == 'h8000 || a == 'hB000 || a == 'hB0FF || a == 'hB1FF) begin
      outer_m = d & 'h30;
      v = (d & 'h30) | 'h0F;
      prg_mb = '{2*d, 2*d+1, 2*v, 2*v+1};
      prg_ms = prg_mb;
    end else if (a == 'h8100) mir_m = d & 3;
    else if (a >= 'h8300 && a <= 'h8302) begin
      prg_mb[a-'h8300] = d; prg_ms[a-'h8300] = d;
    end else if (a == 'h8318) begin
      v = outer_m | d;
      prg_mb[0] = 2*v; prg_mb[1] = 2*v+1;
      prg_ms[0] = 2*v; prg_ms[1] = 2*v+1;
    end else if (a >= 'h8310 && a <= 'h8317) begin
      v = (outer_m << 4) | d;
      p = a - 'h8310;
      if (chr2k_mode && (p == 0 || p == 1 || p == 6 || p == 7)) begin
        p = (p >= 6) ? p - 4 : p;
        chr_m[2*p] = 2*v; chr_m[2*p+1] = 2*v+1;
      end else chr_m[p] = v;
    end else if (a >= 'h5101 && a <= 'h5103) scr_m = d;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    model(a, d);
  endtask

  task automatic chk_prg(input string req);
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 2; k++) begin
        int off = k ? 'h1ABC : 'h0013;
        @(negedge clk);
        cpu_addr = 16'('h8000 | (s << 13) | off);
        #1;
        cmp(req, int'(prg_b), ((prg_mb[s] % PB_BIG) << 13) | off);
        cmp(req, int'(prg_s), ((prg_ms[s] % PB_SMALL) << 13) | off);
      end
    end
  endtask

  task automatic chk_chr(input string req);
    for (int s = 0; s < 8; s++) begin
      int off = (s % 2) ? 'h3FF : 'h155;
      @(negedge clk);
      ppu_addr = 13'((s << 10) | off);
      #1;
      cmp(req, int'(chr_b), ((chr_m[s] % CB) << 10) | off);
    end
  endtask

  task automatic chk_read(input string req, input int a);
    int exp;
    @(negedge clk);
    cpu_addr = 16'(a);
    #1;
    exp = ((a & 'h5100) == 'h5100) ? scr_m : (a >> 8);
    cmp(req, int'(rdata_b), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0;
    ppu_addr = '0; chr2k_mode = 1'b0;
    prg_mb = '{0, 1, 30, 31};
    prg_ms = '{0, 1, 14, 15};
    for (int i = 0; i < 8; i++) chr_m[i] = i;
    outer_m = 0; mir_m = 0; scr_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset mapping on both sizes
    chk_prg("R1");
    chk_chr("R2");
    cmp("R2", int'(mir_b), 0);
    chk_read("R2", 'h5100);

    // R9: scratch writes; 0x5100 is not a scratch address
    wr('h5102, 'hA5);
    chk_read("R9", 'h5100);
    wr('h5100, 'h11);
    chk_read("R9", 'h5103);
    wr('h5101, 'h3C);
    chk_read("R9", 'h5100);
    wr('h5103, 'hE7);
    chk_read("R9", 'h7F00);

    // R10: read rule over every high byte
    for (int h = 0; h < 256; h++) chk_read("R10", (h << 8) | 'h37);

    // R4: mirror codes, with junk upper bits
    for (int v = 0; v < 8; v++) begin
      wr('h8100, (v >= 4) ? ('hFC | (v - 4)) : v);
      @(negedge clk); #1;
      cmp("R4", int'(mir_b), mir_m);
    end

    // R3: outer write, all data values, rotating over its four addresses
    for (int d = 0; d < 256; d++) begin
      int al [4] = '{'h8000, 'hB000, 'hB0FF, 'hB1FF};
      wr(al[d % 4], d);
      chk_prg("R3");
    end

    // R5: single 8 KB windows
    wr('h8000, 'h25);
    for (int s = 0; s < 3; s++) begin
      int dv [3] = '{'h00, 'h5A, 'hFF};
      for (int k = 0; k < 3; k++) begin
        wr('h8300 + s, dv[k]);
        chk_prg("R5");
      end
    end

    // R8: 16 KB low half with outer group
    for (int o = 0; o < 4; o++) begin
      int dv [3] = '{'h00, 'h0F, 'hC3};
      for (int k = 0; k < 3; k++) begin
        wr('h8000, (o << 4) | 'h06);
        wr('h8318, dv[k]);
        chk_prg("R8");
      end
    end

    // R6: 1 KB character windows, strap low
    chr2k_mode = 1'b0;
    for (int o = 0; o < 4; o++) begin
      wr('hB000, o << 4);
      for (int i = 0; i < 8; i++) wr('h8310 + i, (i * 37 + o * 91) & 'hFF);
      chk_chr("R6");
    end
    wr('h8000, 'h00);
    chk_chr("R6");

    // R7: 2 KB character writes, strap high
    chr2k_mode = 1'b1;
    wr('h8000, 'h20);
    for (int i = 0; i < 8; i++) wr('h8310 + i, 'h40 + i * 21);
    chk_chr("R7");
    wr('h8000, 'h30);
    wr('h8310, 'hFF);
    wr('h8317, 'h80);
    wr('h8313, 'hEE);
    chk_chr("R7");
    chr2k_mode = 1'b0;

    // R11: wraps (small program ROM, large character bank numbers)
    wr('h8300, 'hC5);
    wr('h8301, 'h3F);
    chk_prg("R11");
    chk_chr("R11");

    // R12: idle strobe and unused addresses change nothing
    @(negedge clk);
    cpu_addr = 16'h8300; cpu_wdata = 8'h77; cpu_we = 1'b0;
    @(negedge clk);
    cpu_addr = 16'h8100; cpu_wdata = 8'h02;
    @(negedge clk);
    wr('h8303, 'h12);
    wr('h8319, 'h34);
    wr('h8101, 'h03);
    wr('h8308, 'h56);
    chk_prg("R12");
    chk_chr("R12");
    cmp("R12", int'(mir_b), mir_m);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule